// File: doc/BRIEF.md
# Eight-level vectored interrupt controller

This block arbitrates eight peripheral request lines for a small CPU. A rising edge on a request line marks that level as pending. A software-written mask removes levels from arbitration, but their pending bits are kept. The highest-ranked unmasked pending level is compared with the levels the CPU is already servicing. When it outranks all of them, the single interrupt output goes high.

The CPU answers with two acknowledge pulses. The first pulse moves the winning level from pending into service. The second pulse returns a vector byte made from a programmable base and the level number. Software ends each service routine with a non-specific end-of-interrupt command, which retires the most urgent level in service.

Several controllers can be chained. A master marks the levels that have a slave attached, and drives the level number on three ID lines between the two pulses. A slave compares those lines with its own ID, and only a matching slave returns its vector.

Top module: `irq_ctrl8`

## Requirements
- R1: After synchronous reset the pending, in-service and mask registers are all zero, the vector base is zero, the block is a master with no slaves attached, and `cpu_irq`, `vec_valid` and `casc_oe` are low.
- R2: A 0-to-1 change on `req_in[k]`, seen at a clock edge, sets pending bit k. Register reads show bit k of the byte as level k. A line held high does not set its bit again after the bit has been cleared.
- R3: A write with `bus_addr`=1 loads the mask, where bit k=1 masks level k. A masked level keeps its pending bit but never wins arbitration. Masking higher-ranked levels does not stop a lower-ranked unmasked level from winning.
- R4: Priority is fixed: level 0 ranks highest and level 7 lowest. The winner is the lowest-numbered unmasked pending level.
- R5: `cpu_irq` is high exactly when a winner exists, no acknowledge sequence is half-done, and either no level is in service or the winner's number is below that of every level in service.
- R6: The first acknowledge pulse sets the winner's in-service bit and clears its pending bit.
- R7: On the second acknowledge pulse a master with no slave on that level drives `vec_out` = {base, level} and holds `vec_valid` high for exactly one cycle, starting in the cycle after the pulse. If no winner existed at the first pulse, level 7 is reported and nothing enters service.
- R8: A write with `bus_addr`=0 and `wdata[7:6]`=00 is a non-specific end-of-interrupt. It clears the lowest-numbered set in-service bit.
- R9: Command `wdata[7:6]`=11 sets slave-attached bit `wdata[2:0]` to `wdata[3]`. For an attached level, a master holds `casc_oe` high with `casc_out` equal to the level, from the first acknowledge pulse until the second. The master gives no vector for that level.
- R10: Command `wdata[7:6]`=10 selects slave mode (`wdata[3]`=1) and the own ID (`wdata[2:0]`). Command `wdata[7:6]`=01 loads the vector base from `wdata[4:0]`. A slave gives its vector on the second pulse only when `casc_in` equals its ID.
- R11: If a new rising edge on a level arrives in the same cycle as the first acknowledge pulse that clears that level, the pending bit stays set.
- R12: `rdata` is registered. In the cycle after `bus_rd`, it shows the pending register when `bus_addr`=0 and the mask when `bus_addr`=1. Without `bus_rd` it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_in | input | 8 | Peripheral request lines, edge-detected |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 1 | Selects command/pending (0) or mask (1) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| ack | input | 1 | Acknowledge pulse from CPU, one cycle each |
| cpu_irq | output | 1 | Interrupt request to CPU |
| vec_out | output | 8 | Vector byte |
| vec_valid | output | 1 | Vector present, one cycle |
| casc_in | input | 3 | Cascade ID seen by a slave |
| casc_out | output | 3 | Cascade ID driven by a master |
| casc_oe | output | 1 | Master is driving `casc_out` |

## Verification
Two updates can land on the pending register in the same cycle: the clear from the first acknowledge pulse and the set from a fresh request edge. The bench provokes this by raising a request line again in the very cycle it acknowledges that level. It then expects the pending bit to survive, which it checks by reading the register back after the sequence. The same acknowledge also has to come back with the right vector. Nesting is judged separately: the bench holds one level in service, checks `cpu_irq` for higher- and lower-ranked arrivals, and then retires the levels one by one with end-of-interrupt.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int NLVL   = 8;
    localparam int LVL_W  = $clog2(NLVL);
    localparam int DW     = 8;
    localparam int BASE_W = DW - LVL_W;

    typedef logic [LVL_W-1:0] lvl_t;
    typedef logic [NLVL-1:0]  lvlset_t;

    typedef struct packed {
        logic valid;
        lvl_t lvl;
    } pick_t;

    typedef enum logic [1:0] {
        CMD_EOI  = 2'b00,
        CMD_BASE = 2'b01,
        CMD_MODE = 2'b10,
        CMD_CASC = 2'b11
    } cmd_e;

    typedef struct packed {
        logic              slave;
        lvl_t              id;
        logic [BASE_W-1:0] base;
        lvlset_t           casc_map;
    } cfg_t;

    // lowest-numbered set bit wins (level 0 ranks highest)
    function automatic pick_t pick_lowest(input lvlset_t v);
        pick_t p;
        p = '0;
        for (int i = NLVL - 1; i >= 0; i--) begin
            if (v[i]) begin
                p.valid = 1'b1;
                p.lvl   = lvl_t'(i);
            end
        end
        return p;
    endfunction

    function automatic lvlset_t lvl_onehot(input lvl_t l);
        lvlset_t one;
        one = lvlset_t'(1);
        return one << l;
    endfunction
endpackage

// File: rtl/irq_req_latch.sv
module irq_req_latch
    import irq_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  lvlset_t req_in,
    input  logic    clr_en,
    input  lvl_t    clr_lvl,
    output lvlset_t irr
);
    lvlset_t req_q;
    lvlset_t rise;
    lvlset_t clr;

    always_comb begin
        rise = req_in & ~req_q;
        clr  = clr_en ? lvl_onehot(clr_lvl) : '0;
    end

    // a fresh edge has precedence over the acknowledge clear
    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= '0;
            irr   <= '0;
        end else begin
            req_q <= req_in;
            irr   <= (irr & ~clr) | rise;
        end
    end
endmodule

// File: rtl/irq_regs.sv
module irq_regs
    import irq_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic          bus_addr,
    input  logic [DW-1:0] wdata,
    input  lvlset_t       irr,
    output logic [DW-1:0] rdata,
    output lvlset_t       imr,
    output cfg_t          cfg,
    output logic          eoi
);
    cmd_e cmd;

    always_comb begin
        cmd = cmd_e'(wdata[DW-1:DW-2]);
        eoi = bus_wr && !bus_addr && (cmd == CMD_EOI);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            imr   <= '0;
            cfg   <= '0;
            rdata <= '0;
        end else begin
            if (bus_wr && bus_addr) begin
                imr <= lvlset_t'(wdata);
            end else if (bus_wr) begin
                case (cmd)
                    CMD_BASE: cfg.base <= wdata[BASE_W-1:0];
                    CMD_MODE: begin
                        cfg.slave <= wdata[LVL_W];
                        cfg.id    <= wdata[LVL_W-1:0];
                    end
                    CMD_CASC: cfg.casc_map[wdata[LVL_W-1:0]] <= wdata[LVL_W];
                    default: ;
                endcase
            end
            if (bus_rd) begin
                rdata <= bus_addr ? DW'(imr) : DW'(irr);
            end
        end
    end
endmodule

// File: rtl/irq_resolver.sv
module irq_resolver
    import irq_pkg::*;
(
    input  lvlset_t irr,
    input  lvlset_t imr,
    input  lvlset_t isr,
    output pick_t   win,
    output logic    raise
);
    pick_t top;

    always_comb begin
        win   = pick_lowest(irr & ~imr);
        top   = pick_lowest(isr);
        raise = win.valid && (!top.valid || (win.lvl < top.lvl));
    end
endmodule

// File: rtl/irq_ack_seq.sv
module irq_ack_seq
    import irq_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          ack,
    input  logic          eoi,
    input  pick_t         win,
    input  logic          raise,
    input  cfg_t          cfg,
    input  lvl_t          casc_in,
    output lvlset_t       isr,
    output logic          phase,
    output logic          clr_en,
    output lvl_t          clr_lvl,
    output logic          cpu_irq,
    output logic [DW-1:0] vec_out,
    output logic          vec_valid,
    output lvl_t          casc_out,
    output logic          casc_oe
);
    lvl_t    cur_lvl;
    pick_t   top;
    lvlset_t isr_n;
    logic    first_ack;
    logic    second_ack;
    logic    give_vec;

    always_comb begin
        first_ack  = ack && !phase;
        second_ack = ack && phase;
        clr_en     = first_ack && win.valid;
        clr_lvl    = win.lvl;
        cpu_irq    = raise && !phase;
        top        = pick_lowest(isr);
        isr_n      = isr;
        if (eoi && top.valid) begin
            isr_n = isr_n & ~lvl_onehot(top.lvl);
        end
        if (clr_en) begin
            isr_n = isr_n | lvl_onehot(win.lvl);
        end
        give_vec = cfg.slave ? (casc_in == cfg.id) : !casc_oe;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            isr       <= '0;
            phase     <= 1'b0;
            cur_lvl   <= '0;
            vec_out   <= '0;
            vec_valid <= 1'b0;
            casc_out  <= '0;
            casc_oe   <= 1'b0;
        end else begin
            isr       <= isr_n;
            vec_valid <= 1'b0;
            if (first_ack) begin
                phase   <= 1'b1;
                cur_lvl <= win.valid ? win.lvl : '1;
                if (!cfg.slave && win.valid && cfg.casc_map[win.lvl]) begin
                    casc_oe  <= 1'b1;
                    casc_out <= win.lvl;
                end
            end else if (second_ack) begin
                phase   <= 1'b0;
                casc_oe <= 1'b0;
                if (give_vec) begin
                    vec_valid <= 1'b1;
                    vec_out   <= {cfg.base, cur_lvl};
                end
            end
        end
    end
endmodule

// File: rtl/irq_ctrl8.sv
module irq_ctrl8
    import irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] req_in,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic       bus_addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    input  logic       ack,
    output logic       cpu_irq,
    output logic [7:0] vec_out,
    output logic       vec_valid,
    input  logic [2:0] casc_in,
    output logic [2:0] casc_out,
    output logic       casc_oe
);
    lvlset_t irr_w;
    lvlset_t imr_w;
    lvlset_t isr_w;
    cfg_t    cfg_w;
    pick_t   win_w;
    logic    raise_w;
    logic    eoi_w;
    logic    phase_w;
    logic    clr_en_w;
    lvl_t    clr_lvl_w;

    irq_req_latch u_req (
        .clk    (clk),
        .rst    (rst),
        .req_in (req_in),
        .clr_en (clr_en_w),
        .clr_lvl(clr_lvl_w),
        .irr    (irr_w)
    );

    irq_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .bus_wr  (bus_wr),
        .bus_rd  (bus_rd),
        .bus_addr(bus_addr),
        .wdata   (wdata),
        .irr     (irr_w),
        .rdata   (rdata),
        .imr     (imr_w),
        .cfg     (cfg_w),
        .eoi     (eoi_w)
    );

    irq_resolver u_res (
        .irr  (irr_w),
        .imr  (imr_w),
        .isr  (isr_w),
        .win  (win_w),
        .raise(raise_w)
    );

    irq_ack_seq u_ack (
        .clk      (clk),
        .rst      (rst),
        .ack      (ack),
        .eoi      (eoi_w),
        .win      (win_w),
        .raise    (raise_w),
        .cfg      (cfg_w),
        .casc_in  (casc_in),
        .isr      (isr_w),
        .phase    (phase_w),
        .clr_en   (clr_en_w),
        .clr_lvl  (clr_lvl_w),
        .cpu_irq  (cpu_irq),
        .vec_out  (vec_out),
        .vec_valid(vec_valid),
        .casc_out (casc_out),
        .casc_oe  (casc_oe)
    );
endmodule

// File: rtl/irq_ctrl8_chk.sv
module irq_ctrl8_chk
    import irq_pkg::*;
(
    input logic    clk,
    input logic    rst,
    input logic    ack,
    input logic    bus_wr,
    input logic    bus_addr,
    input logic    cpu_irq,
    input logic    vec_valid,
    input logic    casc_oe,
    input lvlset_t irr,
    input lvlset_t imr,
    input lvlset_t isr,
    input logic    phase
);
    lvlset_t below_top;

    always_comb begin
        below_top = (isr & (~isr + lvlset_t'(1))) - lvlset_t'(1);
    end

    p_reset_clear_r1: assert property (@(posedge clk)
        $fell(rst) |-> (irr == '0 && isr == '0 && imr == '0 && !vec_valid && !casc_oe));

    p_irq_unmasked_r3: assert property (@(posedge clk) disable iff (rst)
        cpu_irq |-> (|(irr & ~imr)));

    p_irq_outranks_r5: assert property (@(posedge clk) disable iff (rst)
        cpu_irq |-> (isr == '0 || (|(irr & ~imr & below_top))));

    p_irq_idle_r5: assert property (@(posedge clk) disable iff (rst)
        phase |-> !cpu_irq);

    p_ack_enters_r6: assert property (@(posedge clk) disable iff (rst)
        (ack && !phase && (|(irr & ~imr))) |=> (isr != '0));

    p_vec_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        vec_valid |=> !vec_valid);

    p_isr_stable_r8: assert property (@(posedge clk) disable iff (rst)
        (!ack && !(bus_wr && !bus_addr)) |=> $stable(isr));

    p_oe_in_seq_r9: assert property (@(posedge clk) disable iff (rst)
        casc_oe |-> phase);
endmodule

bind irq_ctrl8 irq_ctrl8_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .ack      (ack),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .cpu_irq  (cpu_irq),
    .vec_valid(vec_valid),
    .casc_oe  (casc_oe),
    .irr      (irr_w),
    .imr      (imr_w),
    .isr      (isr_w),
    .phase    (phase_w)
);

// File: tb/tb_irq_ctrl8.sv
`timescale 1ns/1ps
module tb_irq_ctrl8;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] req_in = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic       bus_addr = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       ack = 1'b0;
    logic       cpu_irq;
    logic [7:0] vec_out;
    logic       vec_valid;
    logic [2:0] casc_in = '0;
    logic [2:0] casc_out;
    logic       casc_oe;

    int n_chk = 0;
    int n_fail = 0;
    localparam logic [7:0] VBASE = 8'h50;  // base 5'h0A shifted above the level

    always #2.5 clk = ~clk;

    irq_ctrl8 dut (.*);

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; wdata = d;
        tick();
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        bus_rd = 1'b1; bus_addr = a;
        tick();
        bus_rd = 1'b0;
        d = rdata;
    endtask

    task automatic pulse_req(input logic [7:0] m);
        req_in = m;
        tick();
        req_in = '0;
        tick();
    endtask

    task automatic eoi();
        wr(1'b0, 8'h00);
    endtask

    task automatic ack2(output logic v, output logic [7:0] vec, output logic oe_mid, output logic [2:0] cas_mid);
        ack = 1'b1; tick(); ack = 1'b0;
        oe_mid = casc_oe; cas_mid = casc_out;
        tick();
        ack = 1'b1; tick(); ack = 1'b0;
        v = vec_valid; vec = vec_out;
        tick();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] rv;
        logic       v;
        logic [7:0] vec;
        logic       oe;
        logic [2:0] cs;

        @(negedge clk);
        repeat (3) tick();
        rst = 1'b0;
        tick();
        // R1 reset state
        chk(!cpu_irq, "R1 irq", cpu_irq, 0);
        chk(!vec_valid, "R1 vec_valid", vec_valid, 0);
        chk(!casc_oe, "R1 casc_oe", casc_oe, 0);
        rd(1'b0, rv); chk(rv == 8'h00, "R1 pending", rv, 0);
        rd(1'b1, rv); chk(rv == 8'h00, "R1 mask", rv, 0);

        // R12 read is registered and holds without a strobe
        pulse_req(8'h02);
        chk(rdata == 8'h00, "R12 hold", rdata, 0);
        rd(1'b0, rv); chk(rv == 8'h02, "R12 read", rv, 8'h02);
        ack2(v, vec, oe, cs); eoi();
        chk(v && vec == 8'h01, "R7 default base", vec, 8'h01);

        wr(1'b0, 8'h4A);  // R10 base = 5'h0A

        // single-level sweep: R2, R5, R6, R7
        for (int k = 0; k < 8; k++) begin
            pulse_req(8'(1 << k));
            rd(1'b0, rv); chk(rv == 8'(1 << k), "R2 edge sets", rv, 8'(1 << k));
            chk(cpu_irq, "R5 raise", cpu_irq, 1);
            ack2(v, vec, oe, cs);
            chk(v && vec == (VBASE | 8'(k)), "R7 vector", {v, vec}, {1'b1, VBASE | 8'(k)});
            rd(1'b0, rv); chk(rv == 8'h00, "R6 pending cleared", rv, 0);
            chk(!cpu_irq, "R5 in service", cpu_irq, 0);
            eoi();
        end

        // R2 held line does not retrigger
        req_in = 8'h08; tick();
        ack2(v, vec, oe, cs); eoi();
        repeat (3) tick();
        rd(1'b0, rv); chk(rv == 8'h00, "R2 held", rv, 0);
        req_in = 8'h00; tick();

        // pair sweep: R4 priority, R5 nesting, R8 EOI
        for (int i = 0; i < 8; i++) begin
            for (int j = i + 1; j < 8; j++) begin
                pulse_req(8'((1 << i) | (1 << j)));
                ack2(v, vec, oe, cs);
                chk(vec == (VBASE | 8'(i)), "R4 winner", vec, VBASE | 8'(i));
                chk(!cpu_irq, "R5 lower blocked", cpu_irq, 0);
                eoi();
                chk(cpu_irq, "R8 eoi frees", cpu_irq, 1);
                ack2(v, vec, oe, cs);
                chk(vec == (VBASE | 8'(j)), "R4 second", vec, VBASE | 8'(j));
                eoi();
            end
        end

        // mask sweep: R3
        pulse_req(8'hFF);
        for (int m = 0; m < 256; m++) begin
            wr(1'b1, 8'(m));
            chk(cpu_irq == (m != 255), "R3 mask irq", cpu_irq, (m != 255));
            rd(1'b1, rv); chk(rv == 8'(m), "R3 mask read", rv, 8'(m));
        end
        rd(1'b0, rv); chk(rv == 8'hFF, "R3 pending kept", rv, 8'hFF);
        for (int k = 0; k < 8; k++) begin
            wr(1'b1, 8'((1 << k) - 1));
            ack2(v, vec, oe, cs);
            chk(vec == (VBASE | 8'(k)), "R3 lower wins", vec, VBASE | 8'(k));
            eoi();
        end
        wr(1'b1, 8'h00);

        // nesting: R5, R8
        pulse_req(8'h20);
        ack2(v, vec, oe, cs);
        pulse_req(8'h04);
        chk(cpu_irq, "R5 higher nests", cpu_irq, 1);
        ack2(v, vec, oe, cs);
        chk(vec == (VBASE | 8'd2), "R5 nested vec", vec, VBASE | 8'd2);
        pulse_req(8'h40);
        chk(!cpu_irq, "R5 lowest waits", cpu_irq, 0);
        eoi();
        chk(!cpu_irq, "R8 clears top only", cpu_irq, 0);
        eoi();
        chk(cpu_irq, "R8 second eoi", cpu_irq, 1);
        ack2(v, vec, oe, cs);
        chk(vec == (VBASE | 8'd6), "R8 vec", vec, VBASE | 8'd6);
        eoi();

        // spurious acknowledge: R7
        ack2(v, vec, oe, cs);
        chk(v && vec == (VBASE | 8'd7), "R7 spurious", vec, VBASE | 8'd7);
        pulse_req(8'h80);
        chk(cpu_irq, "R7 nothing in service", cpu_irq, 1);
        ack2(v, vec, oe, cs); eoi();

        // master cascade: R9
        wr(1'b0, 8'hCC);
        pulse_req(8'h10);
        ack2(v, vec, oe, cs);
        chk(oe && cs == 3'd4, "R9 cascade id", {oe, cs}, {1'b1, 3'd4});
        chk(!v, "R9 no master vector", v, 0);
        chk(!casc_oe, "R9 released", casc_oe, 0);
        eoi();
        wr(1'b0, 8'hC4);

        // same-cycle edge and acknowledge: R11
        pulse_req(8'h40);
        req_in = 8'h40; ack = 1'b1; tick();
        req_in = 8'h00; ack = 1'b0; tick();
        ack = 1'b1; tick(); ack = 1'b0;
        chk(vec_valid && vec_out == (VBASE | 8'd6), "R11 vector", vec_out, VBASE | 8'd6);
        tick();
        rd(1'b0, rv); chk(rv == 8'h40, "R11 pending survives", rv, 8'h40);
        eoi();
        ack2(v, vec, oe, cs); eoi();

        // slave mode: R10
        wr(1'b0, 8'h8D);
        casc_in = 3'd3;
        pulse_req(8'h04);
        ack2(v, vec, oe, cs);
        chk(!v, "R10 other id", v, 0);
        eoi();
        casc_in = 3'd5;
        pulse_req(8'h04);
        ack2(v, vec, oe, cs);
        chk(v && vec == (VBASE | 8'd2), "R10 own id", {v, vec}, {1'b1, VBASE | 8'd2});
        eoi();

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule